// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

A single-channel 32-bit timer behind an APB slave port. Software sets a start value, picks between a repeating period and a wrap-to-all-ones mode, and enables the timer. The counter then decrements by one on every clock. When it has sat at zero for a cycle, it reloads and raises a level interrupt. The interrupt stays pending until software reads a dedicated clear register. A mask bit in the control register suppresses the interrupt output without losing the pending event.

Software can read the live count at any time. Because the counter runs downwards, an up-counting time value is the bitwise inverse of that read. Each register's byte address is an elaboration parameter, so one netlist can be dropped into address maps that place the registers differently.

Top module: `apb_cdtimer`

## Requirements
- R1: After reset the control register reads 0, the start-value register reads 0, the live count reads 0xFFFFFFFF, the status register reads 0 and `irq_o` is 0.
- R2: Default offsets are start value 0x00, live count 0x04, control 0x08, clear 0x0C and status 0x10, each set by its own parameter. Control bit 0 is enable, bit 1 selects periodic mode (1) or wrap mode (0), and bit 2 masks the interrupt. Control and start value read back what was written.
- R3: A write to the start-value register takes effect only while enable is 0. A control write that takes enable from 0 to 1 loads the counter with the start value at that clock edge.
- R4: While enabled, the count falls by one per clock. In periodic mode a count of 0 is followed by the start value, giving a period of start value + 1 cycles.
- R5: In wrap mode a count of 0 is followed by 0xFFFFFFFF.
- R6: While enable is 0 the count holds its value.
- R7: The interrupt becomes pending at the clock edge where an enabled count leaves 0. It stays pending while the timer is disabled. `irq_o` and status bit 0 both equal pending AND NOT mask.
- R8: An APB read of the clear register returns 0 and clears the pending interrupt. If an expiry falls in the same cycle, the pending interrupt stays set.
- R9: Reads of unmapped offsets return 0. Writes to the live-count, clear and status registers change nothing.
- R10: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock for the bus and the counter |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer ready, tied to 1 |
| pslverr | output | 1 | Slave error, tied to 0 |
| irq_o | output | 1 | Level interrupt, pending and not masked |

## Verification
The properties assume that the bus follows the APB two-phase protocol, with a setup cycle followed by exactly one access cycle. They also assume the register offsets are distinct, so that a single access never selects two registers.

The bench drives every transfer through one task pair. That task pair always issues a setup cycle and then a single access cycle, and only ever uses the default offsets or addresses known to be unmapped.

Expected count values are derived from the number of clock edges since the enabling write. The bench therefore changes the start value only while the timer is disabled, which is the condition under which the load rule is defined.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int CDT_W = 32;

  // control field positions, decoded by software
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MODE_BIT = 1;
  localparam int CTL_MASK_BIT = 2;
  localparam int CTL_W        = 3;

  typedef struct packed {
    logic mask;
    logic periodic;
    logic en;
  } ctl_t;

  // register indices for the one-hot decoder
  typedef enum logic [2:0] {
    RI_START  = 3'd0,
    RI_COUNT  = 3'd1,
    RI_CTL    = 3'd2,
    RI_CLEAR  = 3'd3,
    RI_STATUS = 3'd4
  } reg_idx_e;
  localparam int REG_N = 5;

  // value taken by the counter after it has been at zero
  function automatic logic [CDT_W-1:0] cdt_reload(input logic [CDT_W-1:0] start_val,
                                                  input logic periodic);
    return periodic ? start_val : {CDT_W{1'b1}};
  endfunction

  function automatic logic [CDT_W-1:0] cdt_next(input logic [CDT_W-1:0] cur,
                                                input logic [CDT_W-1:0] start_val,
                                                input logic periodic);
    if (cur == '0) return cdt_reload(start_val, periodic);
    return cur - 1'b1;
  endfunction

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_START  = 'h00,
  parameter logic [ADDR_W-1:0] OFS_COUNT  = 'h04,
  parameter logic [ADDR_W-1:0] OFS_CTL    = 'h08,
  parameter logic [ADDR_W-1:0] OFS_CLEAR  = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 'h10
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CDT_W-1:0]  pwdata,
  input  logic [CDT_W-1:0]  count_i,
  input  logic              irq_i,
  output ctl_t              ctl_o,
  output logic [CDT_W-1:0]  start_o,
  output logic              start_evt_o,
  output logic              clear_rd_o,
  output logic [CDT_W-1:0]  prdata
);

  localparam logic [REG_N*ADDR_W-1:0] OFS_TABLE =
    {OFS_STATUS, OFS_CLEAR, OFS_CTL, OFS_COUNT, OFS_START};

  logic [REG_N-1:0] hit;
  logic             wr_acc;
  logic             rd_acc;
  ctl_t             ctl_q;
  logic [CDT_W-1:0] start_q;

  assign wr_acc = psel && penable && pwrite;
  assign rd_acc = psel && penable && !pwrite;

  for (genvar g = 0; g < REG_N; g++) begin : g_dec
    assign hit[g] = (paddr == OFS_TABLE[g*ADDR_W +: ADDR_W]);
  end

  // enable rising through a control write restarts the count
  assign start_evt_o = wr_acc && hit[RI_CTL] && pwdata[CTL_EN_BIT] && !ctl_q.en;
  assign clear_rd_o  = rd_acc && hit[RI_CLEAR];

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      ctl_q   <= '0;
      start_q <= '0;
    end else if (wr_acc) begin
      if (hit[RI_CTL])
        ctl_q <= ctl_t'(pwdata[CTL_W-1:0]);
      if (hit[RI_START] && !ctl_q.en)
        start_q <= pwdata;
    end
  end

  always_comb begin
    prdata = '0;
    if (rd_acc) begin
      unique case (1'b1)
        hit[RI_START]:  prdata = start_q;
        hit[RI_COUNT]:  prdata = count_i;
        hit[RI_CTL]:    prdata = {{(CDT_W-CTL_W){1'b0}}, ctl_q};
        hit[RI_STATUS]: prdata = {{(CDT_W-1){1'b0}}, irq_i};
        default:        prdata = '0;
      endcase
    end
  end

  assign ctl_o   = ctl_q;
  assign start_o = start_q;

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
  import cdt_pkg::*;
(
  input  logic             pclk,
  input  logic             presetn,
  input  logic             en_i,
  input  logic             periodic_i,
  input  logic             start_evt_i,
  input  logic [CDT_W-1:0] start_i,
  output logic [CDT_W-1:0] count_o,
  output logic             expire_o
);

  logic [CDT_W-1:0] count_q;

  assign expire_o = en_i && (count_q == '0);

  always_ff @(posedge pclk) begin
    if (!presetn)
      count_q <= {CDT_W{1'b1}};
    else if (start_evt_i)
      count_q <= start_i;
    else if (en_i)
      count_q <= cdt_next(count_q, start_i, periodic_i);
  end

  assign count_o = count_q;

endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic pclk,
  input  logic presetn,
  input  logic expire_i,
  input  logic clear_rd_i,
  input  logic mask_i,
  output logic pending_o,
  output logic irq_o
);

  logic pending_q;

  // a new expiry outranks a clear in the same cycle
  always_ff @(posedge pclk) begin
    if (!presetn)
      pending_q <= 1'b0;
    else if (expire_i)
      pending_q <= 1'b1;
    else if (clear_rd_i)
      pending_q <= 1'b0;
  end

  assign pending_o = pending_q;
  assign irq_o     = pending_q && !mask_i;

endmodule

// File: rtl/apb_cdtimer.sv
module apb_cdtimer
  import cdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_START  = 'h00,
  parameter logic [ADDR_W-1:0] OFS_COUNT  = 'h04,
  parameter logic [ADDR_W-1:0] OFS_CTL    = 'h08,
  parameter logic [ADDR_W-1:0] OFS_CLEAR  = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 'h10
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq_o
);

  ctl_t             ctl;
  logic [CDT_W-1:0] start_q;
  logic [CDT_W-1:0] count_q;
  logic             start_evt;
  logic             clear_rd;
  logic             expire_evt;
  logic             pending_q;
  logic             ctl_en;
  logic             ctl_periodic;
  logic             ctl_mask;

  assign ctl_en       = ctl.en;
  assign ctl_periodic = ctl.periodic;
  assign ctl_mask     = ctl.mask;

  cdt_regs #(
    .ADDR_W(ADDR_W), .OFS_START(OFS_START), .OFS_COUNT(OFS_COUNT),
    .OFS_CTL(OFS_CTL), .OFS_CLEAR(OFS_CLEAR), .OFS_STATUS(OFS_STATUS)
  ) u_regs (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .count_i(count_q), .irq_i(irq_o),
    .ctl_o(ctl), .start_o(start_q), .start_evt_o(start_evt),
    .clear_rd_o(clear_rd), .prdata(prdata)
  );

  cdt_counter u_cnt (
    .pclk(pclk), .presetn(presetn), .en_i(ctl_en), .periodic_i(ctl_periodic),
    .start_evt_i(start_evt), .start_i(start_q),
    .count_o(count_q), .expire_o(expire_evt)
  );

  cdt_irq u_irq (
    .pclk(pclk), .presetn(presetn), .expire_i(expire_evt),
    .clear_rd_i(clear_rd), .mask_i(ctl_mask),
    .pending_o(pending_q), .irq_o(irq_o)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/cdt_chk.sv
module cdt_chk (
  input logic        pclk,
  input logic        presetn,
  input logic        pready,
  input logic        pslverr,
  input logic        ctl_en,
  input logic        ctl_periodic,
  input logic        ctl_mask,
  input logic [31:0] start_q,
  input logic [31:0] count_q,
  input logic        start_evt,
  input logic        expire_evt,
  input logic        clear_rd,
  input logic        pending_q,
  input logic        irq_o
);

  p_bus_ok_r10: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);

  p_load_on_start_r3: assert property (@(posedge pclk) disable iff (!presetn)
    start_evt |=> count_q == $past(start_q));

  p_step_down_r4: assert property (@(posedge pclk) disable iff (!presetn)
    ctl_en && !expire_evt |=> count_q == $past(count_q) - 32'd1);

  p_periodic_reload_r4: assert property (@(posedge pclk) disable iff (!presetn)
    expire_evt && ctl_periodic |=> count_q == $past(start_q));

  p_wrap_reload_r5: assert property (@(posedge pclk) disable iff (!presetn)
    expire_evt && !ctl_periodic |=> count_q == 32'hFFFF_FFFF);

  p_hold_r6: assert property (@(posedge pclk) disable iff (!presetn)
    !ctl_en && !start_evt |=> $stable(count_q));

  p_set_pending_r7: assert property (@(posedge pclk) disable iff (!presetn)
    expire_evt |=> pending_q);

  p_sticky_r7: assert property (@(posedge pclk) disable iff (!presetn)
    pending_q && !clear_rd |=> pending_q);

  p_masked_r7: assert property (@(posedge pclk) disable iff (!presetn)
    ctl_mask |-> !irq_o);

  p_clear_r8: assert property (@(posedge pclk) disable iff (!presetn)
    clear_rd && !expire_evt |=> !pending_q);

endmodule

bind apb_cdtimer cdt_chk u_chk (
  .pclk(pclk), .presetn(presetn), .pready(pready), .pslverr(pslverr),
  .ctl_en(ctl_en), .ctl_periodic(ctl_periodic), .ctl_mask(ctl_mask),
  .start_q(start_q), .count_q(count_q), .start_evt(start_evt),
  .expire_evt(expire_evt), .clear_rd(clear_rd), .pending_q(pending_q),
  .irq_o(irq_o)
);

// File: tb/apb_cdtimer_tb.sv
`timescale 1ns/1ps
module apb_cdtimer_tb;

  localparam logic [7:0] A_START = 8'h00, A_COUNT = 8'h04, A_CTL = 8'h08,
                         A_CLEAR = 8'h0C, A_STATUS = 8'h10;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int unsigned cyc = 0;
  int unsigned en_cyc = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 pclk = ~pclk;
  always @(posedge pclk) cyc <= cyc + 1;

  apb_cdtimer u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read access phase
  always @(negedge pclk) begin
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) check("scoreboard empty", 32'd1, 32'd0);
      else check(tag_q.pop_front(), prdata, exp_q.pop_front());
    end
  end

  // count expected n edges after an enabling write with start value L
  function automatic logic [31:0] model_count(input logic [31:0] l, input bit per,
                                              input int unsigned n);
    if (n <= l) return l - n;
    if (per) return l - 32'(n % (l + 1));
    return 32'hFFFF_FFFF - 32'(n - l - 1);
  endfunction

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge pclk); #1 psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(posedge pclk); #1 penable = 1;
    @(posedge pclk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge pclk); #1 psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(posedge pclk); #1 penable = 1; exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge pclk); #1 psel = 0; penable = 0;
  endtask

  task automatic apb_rd_live(input logic [31:0] l, input bit per, input string tag);
    @(posedge pclk); #1 psel = 1; pwrite = 0; penable = 0; paddr = A_COUNT;
    @(posedge pclk); #1 penable = 1;
    exp_q.push_back(model_count(l, per, cyc - en_cyc)); tag_q.push_back(tag);
    @(posedge pclk); #1 psel = 0; penable = 0;
  endtask

  task automatic enable_wr(input logic [31:0] ctl);
    apb_wr(A_CTL, ctl);
    en_cyc = cyc;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge pclk);
    #1;
  endtask

  initial begin
    logic [31:0] held;
    edges(3);
    presetn = 1'b1;
    edges(1);
    // R1 reset state
    check("R1 irq after reset", {31'b0, irq_o}, 32'd0);
    check("R10 pready/pslverr", {30'b0, pready, pslverr}, 32'd2);
    apb_rd(A_CTL, 32'd0, "R1 ctl reset");
    apb_rd(A_START, 32'd0, "R1 start reset");
    apb_rd(A_COUNT, 32'hFFFF_FFFF, "R1 count reset");
    apb_rd(A_STATUS, 32'd0, "R1 status reset");

    // R2 readback, periodic run with start value 5
    apb_wr(A_START, 32'd5);
    apb_rd(A_START, 32'd5, "R2 start readback");
    enable_wr(32'h3);
    apb_rd_live(32'd5, 1'b1, "R3 count loaded and falling");
    check("R7 no irq before expiry", {31'b0, irq_o}, 32'd0);
    edges(3);
    check("R7 irq at expiry", {31'b0, irq_o}, 32'd1);
    apb_rd_live(32'd5, 1'b1, "R4 periodic reload");
    apb_rd(A_STATUS, 32'd1, "R7 status pending");
    apb_rd(A_CTL, 32'd3, "R2 ctl readback");

    // R3 start value writes ignored while enabled
    apb_wr(A_START, 32'd100);
    apb_wr(A_CTL, 32'h2);
    held = model_count(32'd5, 1'b1, cyc - en_cyc);
    apb_rd(A_START, 32'd5, "R3 start write ignored when enabled");
    // R6 hold while disabled
    apb_rd(A_COUNT, held, "R6 hold first");
    edges(10);
    apb_rd(A_COUNT, held, "R6 hold later");
    check("R7 pending kept while disabled", {31'b0, irq_o}, 32'd1);
    // R8 clear read
    apb_rd(A_CLEAR, 32'd0, "R8 clear read data");
    check("R8 irq cleared", {31'b0, irq_o}, 32'd0);

    // R7 masking
    enable_wr(32'h7);
    edges(8);
    check("R7 masked irq", {31'b0, irq_o}, 32'd0);
    apb_rd(A_STATUS, 32'd0, "R7 masked status");
    apb_wr(A_CTL, 32'h3);
    check("R7 unmask shows pending", {31'b0, irq_o}, 32'd1);
    apb_wr(A_CTL, 32'h0);
    apb_rd(A_CLEAR, 32'd0, "R8 clear read data 2");
    check("R8 irq cleared 2", {31'b0, irq_o}, 32'd0);

    // R5 wrap mode with start value 3
    apb_wr(A_START, 32'd3);
    enable_wr(32'h1);
    apb_rd_live(32'd3, 1'b0, "R4 wrap mode early count");
    edges(4);
    apb_rd_live(32'd3, 1'b0, "R5 wrap to all ones");
    check("R7 irq in wrap mode", {31'b0, irq_o}, 32'd1);
    apb_wr(A_CTL, 32'h0);
    held = model_count(32'd3, 1'b0, cyc - en_cyc);
    apb_rd(A_CLEAR, 32'd0, "R8 clear read data 3");

    // R9 unmapped and read-only registers
    apb_rd(8'h14, 32'd0, "R9 unmapped 0x14");
    apb_rd(8'hFC, 32'd0, "R9 unmapped 0xFC");
    apb_wr(A_COUNT, 32'h1234);
    apb_rd(A_COUNT, held, "R9 count write ignored");
    apb_wr(A_STATUS, 32'h1);
    apb_wr(A_CLEAR, 32'hFFFF_FFFF);
    apb_rd(A_STATUS, 32'd0, "R9 status write ignored");
    apb_rd(A_CTL, 32'd0, "R9 ctl unchanged");
    check("R10 pready/pslverr end", {30'b0, pready, pslverr}, 32'd2);

    edges(2);
    if (exp_q.size() != 0) check("scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule